// File: doc/BRIEF.md
# Serial Command Frame Decoder

This block sits behind a UART receiver in a logic-analyzer front end. It takes the received byte stream and splits it into commands. A byte whose bit 7 is clear is a complete one-byte command. A byte whose bit 7 is set opens a five-byte frame: the opcode, then four argument bytes. The decoder emits one-cycle strobes for the reset, run and metadata-request commands. It answers the identify command by streaming a fixed four-character string through a byte-wide valid/ready transmit port.

Completed long frames are presented on a write port as opcode plus 32-bit argument, qualified by a one-cycle strobe. Three of these opcodes also load local configuration registers that feed the sampler:
- the sample-clock divider;
- the capture sizes (read count and delay count);
- the acquisition flags.

Since 0x00 is the reset opcode, a host that sends five 0x00 bytes returns the decoder to opcode framing wherever it stood inside a frame.

The framing state machine has five named states:
- `S_OPC` waits for an opcode.
- `S_ARG1`, `S_ARG2`, `S_ARG3` and `S_ARG4` each wait for one argument byte.

It has four named transitions:
- **open** (`S_OPC` to `S_ARG1`): an accepted byte has bit 7 set.
- **collect** (`S_ARGn` to `S_ARGn+1`): an accepted argument byte.
- **close** (`S_ARG4` to `S_OPC`): the fourth argument byte, which fires the write strobe.
- **stay** (`S_OPC` to `S_OPC`): any short opcode.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After reset, `tx_valid`, `cfg_we`, `run_pulse`, `reset_pulse` and `meta_req` are 0. `div_value`, `read_m1` and `delay_m1` are 0, all flag outputs are 0, and `grp_en` is 4'b1111.
- R2: An accepted byte with bit 7 set starts a long frame that takes the next four accepted bytes as its argument. The first argument byte is placed in bits 7:0 and the last in bits 31:24. In the cycle after the fourth argument byte is accepted, `cfg_we` is 1 for exactly one cycle, with `cfg_op` equal to the opcode and `cfg_arg` equal to the assembled argument. `cfg_we` stays 0 after the opcode byte and after the first three argument bytes.
- R3: An accepted byte with bit 7 clear is a complete command. Opcode 0x01 pulses `run_pulse` and opcode 0x04 pulses `meta_req`, each in the cycle after the byte is accepted. At most one strobe is high in any cycle.
- R4: Opcode 0x00 pulses `reset_pulse` in the cycle after it is accepted. Five consecutive 0x00 bytes always leave the decoder in opcode framing, from any position inside a frame, so the next byte is decoded as an opcode.
- R5: Opcode 0x02 makes the transmit port present 0x31, 0x53, 0x4C and 0x4F in that order. Each byte advances on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_byte` holds steady while `tx_ready` is 0, and `tx_valid` falls after the fourth byte.
- R6: Short opcodes other than 0x00, 0x01, 0x02 and 0x04 produce no strobe and no transmit activity, and leave the decoder in opcode framing.
- R7: A completed frame with opcode 0x80 loads `div_value` with argument bits 23:0, one cycle after `cfg_we`.
- R8: A completed frame with opcode 0x81 loads `read_m1` with argument bits 31:16 and `delay_m1` with argument bits 15:0, one cycle after `cfg_we`.
- R9: A completed frame with opcode 0x82 loads the flags one cycle after `cfg_we`:
  - `flag_demux` takes argument bit 0.
  - `flag_filter` takes argument bit 1.
  - `flag_rle` takes argument bit 8.
  - `grp_en[i]` takes the inverse of argument bit 2+i, for i = 0..3.
- R10: A reset opcode accepted while the identification string is being sent ends the transfer: `tx_valid` is 0 in the cycle after `reset_pulse`.
- R11: Completed frames with any long opcode other than 0x80, 0x81 or 0x82 still strobe `cfg_we`, but leave every configuration output unchanged.
- R12: Cycles with `rx_valid` low, including gaps between argument bytes, neither advance the framing nor produce a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts `tx_byte` this cycle |
| tx_valid | output | 1 | An identification byte is offered |
| tx_byte | output | 8 | Identification byte |
| cfg_we | output | 1 | One-cycle strobe for a completed long frame |
| cfg_op | output | 8 | Opcode of the completed frame |
| cfg_arg | output | 32 | Assembled 32-bit argument |
| run_pulse | output | 1 | Start-acquisition strobe |
| reset_pulse | output | 1 | Reset-command strobe |
| meta_req | output | 1 | Metadata-request strobe for the separate metadata source |
| div_value | output | 24 | Sample-clock divider (rate = clock / (divider + 1)) |
| read_m1 | output | 16 | Read count minus one, in units of four samples |
| delay_m1 | output | 16 | Delay count minus one, in units of four samples |
| flag_demux | output | 1 | Double-rate demultiplexed sampling |
| flag_filter | output | 1 | Noise-filter enable |
| flag_rle | output | 1 | Run-length encoding enable |
| grp_en | output | 4 | Enables for the four 8-bit channel groups |

## Verification
The assertions check these properties on every cycle:
- Strobes are mutually exclusive.
- Every strobe follows an accepted byte.
- `cfg_op` carries a long opcode whenever `cfg_we` is high.
- The transmit byte holds while stalled.
- A reset command drops `tx_valid`.
- `grp_en` follows the inverted group bits of the last flags frame.

Some properties depend on stream history and are shown only by the bench's scenarios:
- The exact argument byte order.
- The five-zero resynchronisation from each frame position.
- The order of the identification characters.
- The per-opcode register effects.

The bench gets these from sweeps over all 128 short and all 128 long opcodes and over every resync entry point.

// File: rtl/cmdfd_pkg.sv
package cmdfd_pkg;
    localparam logic [7:0] OP_RESET = 8'h00;
    localparam logic [7:0] OP_RUN   = 8'h01;
    localparam logic [7:0] OP_IDENT = 8'h02;
    localparam logic [7:0] OP_META  = 8'h04;
    localparam logic [7:0] OP_DIV   = 8'h80;
    localparam logic [7:0] OP_SIZE  = 8'h81;
    localparam logic [7:0] OP_FLAGS = 8'h82;

    typedef enum logic [2:0] {
        S_OPC,
        S_ARG1,
        S_ARG2,
        S_ARG3,
        S_ARG4
    } frame_state_t;
endpackage

// File: rtl/cmdfd_framer.sv
module cmdfd_framer
    import cmdfd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ARG_BYTES = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_valid,
    input  logic [BYTE_W-1:0]             rx_byte,
    output logic                          cfg_we,
    output logic [BYTE_W-1:0]             cfg_op,
    output logic [ARG_BYTES*BYTE_W-1:0]   cfg_arg,
    output logic                          run_pulse,
    output logic                          reset_pulse,
    output logic                          meta_req,
    output logic                          id_go
);
    localparam int ARG_W = ARG_BYTES * BYTE_W;

    frame_state_t state, nxt;
    logic         long_op;

    assign long_op = rx_byte[BYTE_W-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_OPC;
        else        state <= nxt;
    end

    // transitions: open, collect, close, stay
    always_comb begin
        nxt = state;
        unique case (state)
            S_OPC:  if (rx_valid && long_op) nxt = S_ARG1;
            S_ARG1: if (rx_valid) nxt = S_ARG2;
            S_ARG2: if (rx_valid) nxt = S_ARG3;
            S_ARG3: if (rx_valid) nxt = S_ARG4;
            S_ARG4: if (rx_valid) nxt = S_OPC;
            default: nxt = S_OPC;
        endcase
    end

    // outputs: strobes, opcode latch, argument shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_we      <= 1'b0;
            cfg_op      <= '0;
            cfg_arg     <= '0;
            run_pulse   <= 1'b0;
            reset_pulse <= 1'b0;
            meta_req    <= 1'b0;
            id_go       <= 1'b0;
        end else begin
            cfg_we      <= 1'b0;
            run_pulse   <= 1'b0;
            reset_pulse <= 1'b0;
            meta_req    <= 1'b0;
            id_go       <= 1'b0;
            if (rx_valid) begin
                if (state == S_OPC) begin
                    if (long_op) begin
                        cfg_op <= rx_byte;
                    end else begin
                        reset_pulse <= (rx_byte == OP_RESET);
                        run_pulse   <= (rx_byte == OP_RUN);
                        id_go       <= (rx_byte == OP_IDENT);
                        meta_req    <= (rx_byte == OP_META);
                    end
                end else begin
                    // first argument byte ends up least significant
                    cfg_arg <= {rx_byte, cfg_arg[ARG_W-1:BYTE_W]};
                    cfg_we  <= (state == S_ARG4);
                end
            end
        end
    end
endmodule

// File: rtl/cmdfd_idtx.sv
module cmdfd_idtx #(
    parameter int BYTE_W = 8,
    parameter int N_CHARS = 4,
    parameter logic [N_CHARS*BYTE_W-1:0] ID_STR = 32'h4F4C5331
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);
    localparam int IDX_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_CHARS - 1);

    logic             busy;
    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (abort) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end else if (busy && tx_ready) begin
            if (idx == LAST) busy <= 1'b0;
            else             idx  <= idx + 1'b1;
        end
    end

    assign tx_valid = busy;
    assign tx_byte  = ID_STR[idx*BYTE_W +: BYTE_W];
endmodule

// File: rtl/cmdfd_cfgregs.sv
module cmdfd_cfgregs
    import cmdfd_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ARG_W = 32,
    parameter int DIV_W = 24,
    parameter int CNT_W = 16,
    parameter int GROUPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BYTE_W-1:0] op,
    input  logic [ARG_W-1:0]  arg,
    output logic [DIV_W-1:0]  div_value,
    output logic [CNT_W-1:0]  read_m1,
    output logic [CNT_W-1:0]  delay_m1,
    output logic              flag_demux,
    output logic              flag_filter,
    output logic              flag_rle,
    output logic [GROUPS-1:0] grp_en
);
    localparam int GRP_LSB = 2;
    localparam int RLE_BIT = 8;

    logic [GROUPS-1:0] grp_off;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_value   <= '0;
            read_m1     <= '0;
            delay_m1    <= '0;
            flag_demux  <= 1'b0;
            flag_filter <= 1'b0;
            flag_rle    <= 1'b0;
            grp_off     <= '0;
        end else if (we) begin
            if (op == OP_DIV) div_value <= arg[DIV_W-1:0];
            if (op == OP_SIZE) begin
                read_m1  <= arg[ARG_W-1 -: CNT_W];
                delay_m1 <= arg[CNT_W-1:0];
            end
            if (op == OP_FLAGS) begin
                flag_demux  <= arg[0];
                flag_filter <= arg[1];
                flag_rle    <= arg[RLE_BIT];
                grp_off     <= arg[GRP_LSB +: GROUPS];
            end
        end
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign grp_en[g] = ~grp_off[g];
    end
endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder #(
    parameter int BYTE_W = 8,
    parameter int ARG_BYTES = 4,
    parameter int DIV_W = 24,
    parameter int CNT_W = 16,
    parameter int GROUPS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_valid,
    input  logic [BYTE_W-1:0]           rx_byte,
    input  logic                        tx_ready,
    output logic                        tx_valid,
    output logic [BYTE_W-1:0]           tx_byte,
    output logic                        cfg_we,
    output logic [BYTE_W-1:0]           cfg_op,
    output logic [ARG_BYTES*BYTE_W-1:0] cfg_arg,
    output logic                        run_pulse,
    output logic                        reset_pulse,
    output logic                        meta_req,
    output logic [DIV_W-1:0]            div_value,
    output logic [CNT_W-1:0]            read_m1,
    output logic [CNT_W-1:0]            delay_m1,
    output logic                        flag_demux,
    output logic                        flag_filter,
    output logic                        flag_rle,
    output logic [GROUPS-1:0]           grp_en
);
    localparam int ARG_W = ARG_BYTES * BYTE_W;

    logic id_go;

    cmdfd_framer #(.BYTE_W(BYTE_W), .ARG_BYTES(ARG_BYTES)) u_framer (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_arg(cfg_arg),
        .run_pulse(run_pulse), .reset_pulse(reset_pulse),
        .meta_req(meta_req), .id_go(id_go)
    );

    cmdfd_idtx #(.BYTE_W(BYTE_W)) u_idtx (
        .clk(clk), .rst_n(rst_n), .start(id_go), .abort(reset_pulse),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    cmdfd_cfgregs #(
        .BYTE_W(BYTE_W), .ARG_W(ARG_W), .DIV_W(DIV_W),
        .CNT_W(CNT_W), .GROUPS(GROUPS)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .op(cfg_op), .arg(cfg_arg),
        .div_value(div_value), .read_m1(read_m1), .delay_m1(delay_m1),
        .flag_demux(flag_demux), .flag_filter(flag_filter),
        .flag_rle(flag_rle), .grp_en(grp_en)
    );
endmodule

// File: rtl/cmdfd_checker.sv
module cmdfd_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_valid,
    input logic        tx_ready,
    input logic        tx_valid,
    input logic [7:0]  tx_byte,
    input logic        cfg_we,
    input logic [7:0]  cfg_op,
    input logic [31:0] cfg_arg,
    input logic        run_pulse,
    input logic        reset_pulse,
    input logic        meta_req,
    input logic        id_go,
    input logic [3:0]  grp_en
);
    assert_we_long_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> cfg_op[7]);

    assert_we_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> $past(rx_valid));

    assert_strobes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_we, run_pulse, reset_pulse, meta_req}));

    // R12: no strobe without a byte accepted on the previous edge
    assert_short_after_byte_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (run_pulse || meta_req || reset_pulse || id_go) |-> $past(rx_valid));

    assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !reset_pulse && !id_go) |=> (tx_valid && $stable(tx_byte)));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_pulse |=> !tx_valid);

    assert_groups_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && ($past(cfg_op) == 8'h82)) |-> (grp_en == ~$past(cfg_arg[5:2])));
endmodule

bind cmd_frame_decoder cmdfd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .cfg_we(cfg_we), .cfg_op(cfg_op),
    .cfg_arg(cfg_arg), .run_pulse(run_pulse), .reset_pulse(reset_pulse),
    .meta_req(meta_req), .id_go(id_go), .grp_en(grp_en)
);

// File: tb/cmd_frame_decoder_test.sv
module cmd_frame_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        tx_ready = 1'b0;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        cfg_we;
    logic [7:0]  cfg_op;
    logic [31:0] cfg_arg;
    logic        run_pulse, reset_pulse, meta_req;
    logic [23:0] div_value;
    logic [15:0] read_m1, delay_m1;
    logic        flag_demux, flag_filter, flag_rle;
    logic [3:0]  grp_en;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    cmd_frame_decoder uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_arg(cfg_arg),
        .run_pulse(run_pulse), .reset_pulse(reset_pulse), .meta_req(meta_req),
        .div_value(div_value), .read_m1(read_m1), .delay_m1(delay_m1),
        .flag_demux(flag_demux), .flag_filter(flag_filter), .flag_rle(flag_rle),
        .grp_en(grp_en)
    );

    logic        s_we, s_run, s_rst, s_meta;
    logic [7:0]  s_op;
    logic [31:0] s_arg;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with strobes sampled
    task automatic send(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        s_we = cfg_we; s_run = run_pulse; s_rst = reset_pulse; s_meta = meta_req;
        s_op = cfg_op; s_arg = cfg_arg;
    endtask

    logic [23:0] e_div;
    logic [15:0] e_rd, e_dl;
    logic        e_dmx, e_flt, e_rle;
    logic [3:0]  e_grp;

    task automatic check_regs(input string req);
        check(div_value == e_div, req, div_value, e_div);
        check({read_m1, delay_m1} == {e_rd, e_dl}, req, {read_m1, delay_m1}, {e_rd, e_dl});
        check({flag_demux, flag_filter, flag_rle, grp_en} == {e_dmx, e_flt, e_rle, e_grp},
              req, {flag_demux, flag_filter, flag_rle, grp_en}, {e_dmx, e_flt, e_rle, e_grp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0]  op;
        logic [31:0] a;
        logic [31:0] idw;
        int          nwe, nrst, w;

        e_div = '0; e_rd = '0; e_dl = '0; e_dmx = 0; e_flt = 0; e_rle = 0; e_grp = 4'hF;
        idw = 32'h4F4C5331;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({tx_valid, cfg_we, run_pulse, reset_pulse, meta_req} == 5'b0, "R1",
              {tx_valid, cfg_we, run_pulse, reset_pulse, meta_req}, 0);
        check_regs("R1");

        // R3 / R4 / R6: sweep every short opcode except identify
        for (int o = 0; o < 128; o++) begin
            if (o == 2) continue;
            op = o[7:0];
            send(op);
            check({s_we, s_run, s_rst, s_meta} == {1'b0, op == 8'h01, op == 8'h00, op == 8'h04},
                  (op == 8'h00) ? "R4" : ((op == 8'h01 || op == 8'h04) ? "R3" : "R6"),
                  {s_we, s_run, s_rst, s_meta}, {1'b0, op == 8'h01, op == 8'h00, op == 8'h04});
            check(!tx_valid, "R6", tx_valid, 0);
            send(8'h01);
            check(s_run && !s_we, "R6", {s_run, s_we}, 2'b10);
        end

        // R2 / R7 / R8 / R9 / R11 / R12: sweep every long opcode with gaps
        for (int o = 128; o < 256; o++) begin
            op = o[7:0];
            a  = {op, ~op, op ^ 8'h5A, 8'h3C ^ {op[3:0], op[7:4]}};
            send(op);
            check(!s_we, "R2", s_we, 0);
            for (int k = 0; k < 4; k++) begin
                repeat (o % 3) begin
                    @(negedge clk);
                    check(!cfg_we, "R12", cfg_we, 0);
                end
                send(a[8*k +: 8]);
                if (k < 3) check(!s_we, "R2", s_we, 0);
            end
            check(s_we && s_op == op && s_arg == a, "R2", {s_op, s_arg[23:0]}, {op, a[23:0]});
            check(s_arg == a, "R2", s_arg, a);
            if (op == 8'h80) e_div = a[23:0];
            if (op == 8'h81) begin e_rd = a[31:16]; e_dl = a[15:0]; end
            if (op == 8'h82) begin
                e_dmx = a[0]; e_flt = a[1]; e_rle = a[8]; e_grp = ~a[5:2];
            end
            @(negedge clk);
            check_regs((op == 8'h80) ? "R7" : (op == 8'h81) ? "R8" : (op == 8'h82) ? "R9" : "R11");
        end

        // R9 extra flag patterns
        for (int p = 0; p < 4; p++) begin
            a = (p == 0) ? 32'h0000_0103 : (p == 1) ? 32'h0000_003C :
                (p == 2) ? 32'h0000_0014 : 32'hFFFF_FEC0;
            send(8'h82);
            for (int k = 0; k < 4; k++) send(a[8*k +: 8]);
            e_dmx = a[0]; e_flt = a[1]; e_rle = a[8]; e_grp = ~a[5:2];
            @(negedge clk);
            check_regs("R9");
        end

        // R4 resync from every position inside a frame, and from opcode framing
        for (int k = 0; k < 5; k++) begin
            nwe = 0; nrst = 0;
            if (k < 4) begin
                send(8'h85);
                for (int j = 0; j < k; j++) send(8'hAA);
            end
            for (int z = 0; z < 5; z++) begin
                send(8'h00);
                nwe += s_we; nrst += s_rst;
            end
            check(nwe == ((k < 4) ? 1 : 0), "R4", nwe, (k < 4) ? 1 : 0);
            check(nrst == ((k < 4) ? k + 1 : 5), "R4", nrst, (k < 4) ? k + 1 : 5);
            send(8'h01);
            check(s_run && !s_we, "R4", {s_run, s_we}, 2'b10);
        end
        @(negedge clk);
        check_regs("R11");

        // R5 identification string with increasing stalls
        send(8'h02);
        for (int k = 0; k < 4; k++) begin
            w = 0;
            while (!tx_valid && w < 20) begin @(negedge clk); w++; end
            repeat (k) begin
                @(negedge clk);
                check(tx_valid && tx_byte == idw[8*k +: 8], "R5", tx_byte, idw[8*k +: 8]);
            end
            check(tx_valid && tx_byte == idw[8*k +: 8], "R5", tx_byte, idw[8*k +: 8]);
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(!tx_valid, "R5", tx_valid, 0);

        // R10 reset command aborts the identification transfer
        send(8'h02);
        w = 0;
        while (!tx_valid && w < 20) begin @(negedge clk); w++; end
        check(tx_valid, "R10", tx_valid, 1);
        send(8'h00);
        check(s_rst, "R10", s_rst, 1);
        @(negedge clk);
        check(!tx_valid, "R10", tx_valid, 0);
        repeat (3) @(negedge clk);
        check(!tx_valid, "R10", tx_valid, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule